// File: doc/BRIEF.md
# SPI Register Access Framer

This block is an SPI slave that lets an external host read and write a word-addressed space of 32-bit registers. Every chip-select frame opens with a 32-bit command word that sets the direction, the starting word address and, for reads, how many words to return. In a write frame the host follows the command with data words, and each complete word becomes one write strobe on the internal register port. In a read frame the block fetches words from the register port and shifts them out on MISO right after the command, one word per 32 SCLK cycles, stepping the address by one each time.

The SPI pins are brought into the system clock domain by a synchroniser chain and sampled there, so SCLK must be well below the system clock. Each half period must last at least six system clock cycles. The register port is synchronous: `reg_rdata` must hold the addressed word in the clock cycle after `reg_rd` is high. MISO reads as zero whenever there is nothing to send. This covers the command phase, the time after the requested words and any time chip-select is high.

Top module: `spi_regport_slave`

## Requirements
- R1: SPI mode 0 with the most significant bit first. MOSI is sampled on rising SCLK edges. MISO changes only after falling edges.
- R2: The first 32 bits of a frame form the command. Bit 31 set to 1 means write and 0 means read. Bits 30:25 are the read word count. Bits 24:4 are the starting word address. Bits 3:0 have no effect.
- R3: In a write frame, each complete 32-bit word after the command produces exactly one single-cycle `reg_wr` pulse, with `reg_wdata` equal to that word.
- R4: In both directions, successive words of a frame use successive word addresses starting at the command address. The address wraps modulo 2^21.
- R5: A write frame produces at most 64 write strobes, and any further words in that frame are dropped.
- R6: A read frame issues exactly N `reg_rd` pulses, one per word, where N is the count field and a count of 0 means 64. The first word fetched appears on MISO in the 32 bits right after the command, and each later word follows in the next 32 bits.
- R7: MISO is 0 during the command, after the N read words have been sent, and while chip-select is high.
- R8: The count field has no effect in a write frame. MOSI data in a read frame causes no write strobe.
- R9: Deasserting chip-select ends the frame. A partly received word causes no strobe, and the next frame starts again with a command.
- R10: After reset, `reg_wr`, `reg_rd` and `spi_miso` are 0.
- R11: `reg_wr` and `reg_rd` are never high in the same cycle, and a strobe never lasts two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| reg_addr | output | 21 | Word address for the current strobe |
| reg_wdata | output | 32 | Write data, valid with `reg_wr` |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 32 | Read data, valid the cycle after `reg_rd` |

## Verification
Most internal faults in this block show up at the register port within one SPI word, which is 32 SCLK periods. A wrong bit counter, a wrong field split in the command decode or a bad address step puts a strobe at the wrong address, gives it the wrong data or removes it altogether. A broken length counter shows up later, as a strobe count other than 64 in the long frames. A fault in the load path between the read data and the shift register reaches only MISO. It therefore appears in the first response word after the command, or as stray bits once the requested words have been sent.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

   // Frame progress as seen by the command decoder.
   typedef enum logic [1:0] {
      PH_CMD   = 2'd0,
      PH_WRITE = 2'd1,
      PH_READ  = 2'd2,
      PH_DROP  = 2'd3
   } phase_e;

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic cs_n_i,
   input  logic mosi_i,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic cs_act,
   output logic mosi_s
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_regport_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sclk_sh;
   logic [STAGES-1:0] cs_sh;
   logic [STAGES-1:0] mosi_sh;
   logic              sclk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_sh   <= '0;
         cs_sh     <= '1;
         mosi_sh   <= '0;
         sclk_prev <= 1'b0;
      end else begin
         sclk_sh   <= {sclk_sh[STAGES-2:0], sclk_i};
         cs_sh     <= {cs_sh[STAGES-2:0], cs_n_i};
         mosi_sh   <= {mosi_sh[STAGES-2:0], mosi_i};
         sclk_prev <= sclk_sh[STAGES-1];
      end
   end

   assign cs_act    = ~cs_sh[STAGES-1];
   assign mosi_s    = mosi_sh[STAGES-1];
   assign sclk_rise = cs_act &  sclk_sh[STAGES-1] & ~sclk_prev;
   assign sclk_fall = cs_act & ~sclk_sh[STAGES-1] &  sclk_prev;

endmodule

// File: rtl/spi_regport_shift.sv
module spi_regport_shift #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic              mosi_s,
   input  logic              load_valid,
   input  logic [WORD_W-1:0] load_word,
   output logic              word_done,
   output logic [WORD_W-1:0] rx_word,
   output logic              miso
);

   localparam int CW = $clog2(WORD_W);

   logic [CW-1:0]     bit_cnt;
   logic [WORD_W-1:0] tx_sh;
   logic [WORD_W-1:0] pend_word;
   logic              pend_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         word_done <= 1'b0;
         rx_word   <= '0;
         tx_sh     <= '0;
         pend_word <= '0;
         pend_v    <= 1'b0;
      end else if (!cs_act) begin
         bit_cnt   <= '0;
         word_done <= 1'b0;
         tx_sh     <= '0;
         pend_v    <= 1'b0;
      end else begin
         word_done <= 1'b0;
         if (sclk_rise) begin
            rx_word   <= {rx_word[WORD_W-2:0], mosi_s};
            word_done <= (bit_cnt == CW'(WORD_W - 1));
            bit_cnt   <= (bit_cnt == CW'(WORD_W - 1)) ? '0 : bit_cnt + 1'b1;
         end
         if (load_valid && !sclk_fall) begin
            pend_word <= load_word;
            pend_v    <= 1'b1;
         end
         if (sclk_fall) begin
            if (load_valid) begin
               tx_sh <= load_word;
            end else if (pend_v) begin
               tx_sh  <= pend_word;
               pend_v <= 1'b0;
            end else begin
               tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
            end
         end
      end
   end

   assign miso = tx_sh[WORD_W-1] & cs_act;

endmodule

// File: rtl/spi_regport_ctl.sv
module spi_regport_ctl
   import spi_regport_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int CNT_W       = 6,
   parameter int ADDR_W      = 21,
   parameter bit ZERO_IS_MAX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              word_done,
   input  logic [DATA_W-1:0] rx_word,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_wr,
   output logic              reg_rd,
   output logic              load_valid,
   output logic [DATA_W-1:0] load_word
);

   localparam int MAX_WORDS = 2 ** CNT_W;
   localparam int LW        = CNT_W + 1;
   localparam int DIR_BIT   = DATA_W - 1;
   localparam int CNT_HI    = DATA_W - 2;
   localparam int CNT_LO    = DATA_W - 1 - CNT_W;
   localparam int ADDR_HI   = CNT_LO - 1;
   localparam int ADDR_LO   = ADDR_HI - ADDR_W + 1;

   phase_e            phase;
   logic [ADDR_W-1:0] addr_q;
   logic [LW-1:0]     left_q;
   logic              rd_late;

   logic              cmd_write;
   logic [CNT_W-1:0]  cmd_cnt;
   logic [ADDR_W-1:0] cmd_addr;
   logic [LW-1:0]     rd_len;

   assign cmd_write = rx_word[DIR_BIT];
   assign cmd_cnt   = rx_word[CNT_HI:CNT_LO];
   assign cmd_addr  = rx_word[ADDR_HI:ADDR_LO];

   generate
      if (ZERO_IS_MAX) begin : g_zero_full
         assign rd_len = (cmd_cnt == '0) ? LW'(MAX_WORDS) : {1'b0, cmd_cnt};
      end else begin : g_zero_none
         assign rd_len = {1'b0, cmd_cnt};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_CMD;
         addr_q    <= '0;
         left_q    <= '0;
         reg_addr  <= '0;
         reg_wdata <= '0;
         reg_wr    <= 1'b0;
         reg_rd    <= 1'b0;
         rd_late   <= 1'b0;
      end else begin
         reg_wr  <= 1'b0;
         reg_rd  <= 1'b0;
         rd_late <= reg_rd;
         if (!cs_act) begin
            phase <= PH_CMD;
         end else if (word_done) begin
            unique case (phase)
               PH_CMD: begin
                  if (cmd_write) begin
                     addr_q <= cmd_addr;
                     left_q <= LW'(MAX_WORDS);
                     phase  <= PH_WRITE;
                  end else if (rd_len != '0) begin
                     reg_rd   <= 1'b1;
                     reg_addr <= cmd_addr;
                     addr_q   <= cmd_addr + 1'b1;
                     left_q   <= rd_len - 1'b1;
                     phase    <= PH_READ;
                  end else begin
                     phase <= PH_DROP;
                  end
               end
               PH_WRITE: begin
                  reg_wr    <= 1'b1;
                  reg_addr  <= addr_q;
                  reg_wdata <= rx_word;
                  addr_q    <= addr_q + 1'b1;
                  left_q    <= left_q - 1'b1;
                  if (left_q == LW'(1)) phase <= PH_DROP;
               end
               PH_READ: begin
                  if (left_q != '0) begin
                     reg_rd   <= 1'b1;
                     reg_addr <= addr_q;
                     addr_q   <= addr_q + 1'b1;
                     left_q   <= left_q - 1'b1;
                  end else begin
                     phase <= PH_DROP;
                  end
               end
               default: phase <= PH_DROP;
            endcase
         end
      end
   end

   assign load_valid = rd_late;
   assign load_word  = reg_rdata;

endmodule

// File: rtl/spi_regport_slave.sv
module spi_regport_slave #(
   parameter int DATA_W      = 32,
   parameter int CNT_W       = 6,
   parameter int ADDR_W      = 21,
   parameter int SYNC_STAGES = 2,
   parameter bit ZERO_IS_MAX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_wr,
   output logic              reg_rd,
   input  logic [DATA_W-1:0] reg_rdata
);

   localparam int MAX_WORDS = 2 ** CNT_W;
   localparam int SPARE_W   = DATA_W - 1 - CNT_W - ADDR_W;

   generate
      if (SPARE_W < 0) begin : g_bad_fields
         $error("spi_regport_slave: command fields exceed DATA_W");
      end
      if ((DATA_W & (DATA_W - 1)) != 0) begin : g_bad_word
         $error("spi_regport_slave: DATA_W must be a power of two");
      end
   endgenerate

   logic              sclk_rise;
   logic              sclk_fall;
   logic              cs_act;
   logic              mosi_s;
   logic              word_done;
   logic [DATA_W-1:0] rx_word;
   logic              load_valid;
   logic [DATA_W-1:0] load_word;

   spi_regport_sync #(
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_i    (spi_sclk),
      .cs_n_i    (spi_cs_n),
      .mosi_i    (spi_mosi),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .cs_act    (cs_act),
      .mosi_s    (mosi_s)
   );

   spi_regport_shift #(
      .WORD_W (DATA_W)
   ) i_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_act     (cs_act),
      .sclk_rise  (sclk_rise),
      .sclk_fall  (sclk_fall),
      .mosi_s     (mosi_s),
      .load_valid (load_valid),
      .load_word  (load_word),
      .word_done  (word_done),
      .rx_word    (rx_word),
      .miso       (spi_miso)
   );

   spi_regport_ctl #(
      .DATA_W      (DATA_W),
      .CNT_W       (CNT_W),
      .ADDR_W      (ADDR_W),
      .ZERO_IS_MAX (ZERO_IS_MAX)
   ) i_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_act     (cs_act),
      .word_done  (word_done),
      .rx_word    (rx_word),
      .reg_rdata  (reg_rdata),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .load_valid (load_valid),
      .load_word  (load_word)
   );

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
   parameter int ADDR_W    = 21,
   parameter int MAX_WORDS = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_act,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              spi_miso
);

   localparam int SW = $clog2(MAX_WORDS + 2);

   logic [SW-1:0]     strobes;
   logic              prev_v;
   logic [ADDR_W-1:0] prev_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobes   <= '0;
         prev_v    <= 1'b0;
         prev_addr <= '0;
      end else if (!cs_act) begin
         strobes <= '0;
         prev_v  <= 1'b0;
      end else if (reg_wr || reg_rd) begin
         strobes   <= strobes + 1'b1;
         prev_v    <= 1'b1;
         prev_addr <= reg_addr;
      end
   end

   a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_rd));

   a_r11_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr);

   a_r11_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> !reg_rd);

   a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_v && cs_act && (reg_wr || reg_rd)) |-> (reg_addr == ADDR_W'(prev_addr + 1'b1)));

   a_r5_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
      strobes <= SW'(MAX_WORDS));

   a_r7_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |-> !spi_miso);

   a_r9_strobe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr || reg_rd) |-> cs_act);

endmodule

bind spi_regport_slave spi_regport_chk #(
   .ADDR_W    (ADDR_W),
   .MAX_WORDS (MAX_WORDS)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_act   (cs_act),
   .reg_wr   (reg_wr),
   .reg_rd   (reg_rd),
   .reg_addr (reg_addr),
   .spi_miso (spi_miso)
);

// File: tb/test_spi_regport_slave.sv
`timescale 1ns/1ps
module test_spi_regport_slave;

   localparam int HALF = 8;
   localparam int WD   = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_sclk = 1'b0;
   logic        spi_cs_n = 1'b1;
   logic        spi_mosi = 1'b0;
   logic        spi_miso;
   logic [20:0] reg_addr;
   logic [31:0] reg_wdata;
   logic        reg_wr;
   logic        reg_rd;
   logic [31:0] reg_rdata = '0;

   always #2.5 clk = ~clk;

   spi_regport_slave i_spi_regport_slave (
      .clk       (clk),
      .rst_n     (rst_n),
      .spi_sclk  (spi_sclk),
      .spi_cs_n  (spi_cs_n),
      .spi_mosi  (spi_mosi),
      .spi_miso  (spi_miso),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_rdata (reg_rdata)
   );

   int n_chk = 0;
   int n_fail = 0;

   logic [31:0] frame_tx [0:71];
   logic [31:0] frame_rx [0:71];
   logic [20:0] wlog_a [0:255];
   logic [31:0] wlog_d [0:255];
   logic [20:0] rlog_a [0:255];
   int wn = 0;
   int rn = 0;

   function automatic logic [31:0] model(input logic [20:0] a);
      return {a[10:0], a} ^ 32'h3C00_0000;
   endfunction

   function automatic logic [31:0] wdat(input int k, input int i);
      logic [31:0] t;
      t = 32'h9E37_79B9 * 32'(k * 100 + i + 1);
      return t;
   endfunction

   // register port model: data valid the cycle after reg_rd; strobe logs
   always @(posedge clk) begin
      if (reg_rd) begin
         reg_rdata <= model(reg_addr);
         rlog_a[rn[7:0]] <= reg_addr;
         rn <= rn + 1;
      end
      if (reg_wr) begin
         wlog_a[wn[7:0]] <= reg_addr;
         wlog_d[wn[7:0]] <= reg_wdata;
         wn <= wn + 1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run_frame(input int nbits);
      spi_cs_n = 1'b0;
      wait_clk(HALF);
      for (int b = 0; b < nbits; b++) begin
         spi_mosi = frame_tx[b / 32][31 - (b % 32)];
         wait_clk(HALF);
         spi_sclk = 1'b1;
         frame_rx[b / 32][31 - (b % 32)] = spi_miso;
         wait_clk(HALF);
         spi_sclk = 1'b0;
      end
      wait_clk(HALF);
      spi_cs_n = 1'b1;
      spi_mosi = 1'b0;
      wait_clk(12);
   endtask

   // {write, count, address, words sent, strobes expected}
   localparam logic [43:0] VECS [8] = '{
      {1'b1, 6'd0, 21'h000010, 8'd1,  8'd1},
      {1'b1, 6'd0, 21'h1FFFFE, 8'd3,  8'd3},
      {1'b0, 6'd2, 21'h000100, 8'd2,  8'd2},
      {1'b0, 6'd1, 21'h012345, 8'd1,  8'd1},
      {1'b0, 6'd3, 21'h00AB00, 8'd5,  8'd3},
      {1'b1, 6'd0, 21'h000040, 8'd66, 8'd64},
      {1'b0, 6'd0, 21'h1FFFF0, 8'd64, 8'd64},
      {1'b1, 6'd5, 21'h000200, 8'd2,  8'd2}
   };

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (WD) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(2);
      // R10: reset state at the ports
      check("R10 miso", {31'd0, spi_miso}, 32'd0);
      check("R10 reg_wr", {31'd0, reg_wr}, 32'd0);
      check("R10 reg_rd", {31'd0, reg_rd}, 32'd0);

      for (int k = 0; k < 8; k++) begin
         logic [43:0] v;
         logic        dir;
         logic [20:0] base;
         int          nw, ne, w0, r0;
         v    = VECS[k];
         dir  = v[43];
         base = v[36:16];
         nw   = int'(v[15:8]);
         ne   = int'(v[7:0]);
         frame_tx[0] = {dir, v[42:37], base, 4'hA};
         for (int i = 0; i < nw; i++) frame_tx[1 + i] = wdat(k, i);
         w0 = wn;
         r0 = rn;
         run_frame(32 * (1 + nw));
         check("R7 miso zero in command", frame_rx[0], 32'd0);
         if (dir) begin
            check(k == 5 ? "R5 write cap" : (k == 7 ? "R8 write count ignored" : "R3 write count"),
                  32'(wn - w0), 32'(ne));
            check("R8 no read in write frame", 32'(rn - r0), 32'd0);
            for (int i = 0; i < ne; i++) begin
               logic [20:0] ea;
               ea = base + 21'(i);
               check("R4 write address", {11'd0, wlog_a[(w0 + i) % 256]}, {11'd0, ea});
               check("R3 write data", wlog_d[(w0 + i) % 256], wdat(k, i));
            end
         end else begin
            check("R6 read count", 32'(rn - r0), 32'(ne));
            check("R8 no write in read frame", 32'(wn - w0), 32'd0);
            for (int i = 0; i < ne; i++) begin
               logic [20:0] ea;
               ea = base + 21'(i);
               check("R4 read address", {11'd0, rlog_a[(r0 + i) % 256]}, {11'd0, ea});
               check("R6 read data on miso", frame_rx[1 + i], model(ea));
            end
            for (int i = ne; i < nw; i++)
               check("R7 miso zero after read", frame_rx[1 + i], 32'd0);
         end
         check("R7 miso idle between frames", {31'd0, spi_miso}, 32'd0);
      end

      // R9: abort inside a write data word
      begin
         int w0;
         w0 = wn;
         frame_tx[0] = {1'b1, 6'd0, 21'h000777, 4'h0};
         frame_tx[1] = 32'hFFFF_FFFF;
         run_frame(32 + 20);
         check("R9 partial word dropped", 32'(wn - w0), 32'd0);
         frame_tx[0] = {1'b1, 6'd0, 21'h000800, 4'h5};
         frame_tx[1] = 32'h1234_5678;
         run_frame(64);
         check("R9 next frame strobes", 32'(wn - w0), 32'd1);
         check("R9 next frame address", {11'd0, wlog_a[w0 % 256]}, 32'h0000_0800);
         check("R1 next frame data", wlog_d[w0 % 256], 32'h1234_5678);
      end

      // R9: abort inside the command, then a clean read
      begin
         int r0;
         r0 = rn;
         frame_tx[0] = 32'hFFFF_FFFF;
         run_frame(15);
         check("R9 partial command no strobe", 32'(rn - r0), 32'd0);
         frame_tx[0] = {1'b0, 6'd1, 21'h000ABC, 4'hF};
         frame_tx[1] = 32'hFFFF_FFFF;
         run_frame(64);
         check("R9 read after abort count", 32'(rn - r0), 32'd1);
         check("R2 read after abort address", {11'd0, rlog_a[r0 % 256]}, 32'h0000_0ABC);
         check("R6 read after abort data", frame_rx[1], model(21'h000ABC));
      end

      finish_run();
   end

endmodule